// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin bidirectional general-purpose I/O port on a simple strobe-based register bus. A data latch holds the values to drive. A direction latch marks each pin as input (1) or output (0). A single active-low configuration bit turns on weak pull-ups for every input pin. The port drives pin values, per-pin output enables and per-pin pull-up requests toward the pads. It reads back the pin levels through a two-flop synchroniser.

The upper pins (7 down to 4) feed a change detector. Each of these pins that is configured as an input is compared with a snapshot. The snapshot is taken on every port read strobe and every port write strobe. Any difference sets a sticky interrupt flag. The flag is set again on every cycle while the difference lasts, so software must access the port before a clear can succeed. A wake request is raised whenever a difference is present or the flag is set, so a sleeping system can be woken.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the data latch is 0x00, every direction bit is 1 (so `pin_oe` is 0x00), the pull-up control bit is 1 (so `pin_pu` is 0x00), and `chg_flag` and `wake_req` are low.
- R2: A `dir_wr` strobe loads `bus_wdata` into the direction latch and a `port_wr` strobe loads it into the data latch, both at the next rising edge. `pin_oe[i]` is the inverse of direction bit i, and `pin_out` equals the data latch. Writing 0xCF gives `pin_oe` = 0x30.
- R3: A `pucfg_wr` strobe loads `bus_wdata[7]` into the active-low pull-up control bit. `pin_pu[i]` is 1 only when that bit is 0 and pin i is an input. A pin configured as an output never has its pull-up on.
- R4: While `port_rd` is high, `rd_data` returns the synchronised pin levels of all eight pins, whatever their direction. A pin change first appears there after the second rising edge.
- R5: While `dir_rd` is high and `port_rd` is low, `rd_data` returns the direction latch. With neither read strobe high, `rd_data` is 0x00.
- R6: Pins 3:0, and any of pins 7:4 configured as an output, never cause a mismatch, so changes on them leave `chg_flag` and `wake_req` low.
- R7: A synchronised input pin among 7:4 that differs from the snapshot sets `chg_flag` at the next rising edge. The flag stays set after the difference ends until it is cleared.
- R8: While a mismatch is present, `chg_clr` has no effect and `chg_flag` stays 1.
- R9: A `port_rd` or `port_wr` strobe copies the synchronised pins into the snapshot at the rising edge and so ends the mismatch. A `chg_clr` pulse in a later cycle with no mismatch then clears `chg_flag`.
- R10: `wake_req` is high whenever a mismatch is present or `chg_flag` is set. It therefore rises one cycle before the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wdata | input | 8 | Write data for all register strobes |
| rd_data | output | 8 | Read data, combinational on the read strobes |
| port_wr | input | 1 | Write data latch; resynchronises snapshot |
| port_rd | input | 1 | Read pin levels; resynchronises snapshot |
| dir_wr | input | 1 | Write direction latch |
| dir_rd | input | 1 | Read direction latch |
| pucfg_wr | input | 1 | Write pull-up control bit from bus_wdata[7] |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Values to drive on the pins |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Sticky port-change interrupt flag |
| chg_clr | input | 1 | Flag clear request |
| wake_req | output | 1 | Wake-up request |

## Verification
A register strobe takes effect at the rising edge where it is high, so its result appears on `pin_out`, `pin_oe` and `pin_pu` from that edge onward. A pin change reaches `rd_data` and `wake_req` after the second edge and sets `chg_flag` at the third. The bench drives every input on the falling edge and samples on later falling edges after counting the edges the result needs. It checks the read data one edge early to show that the old level is still returned. It also checks the flag one edge early to show that the flag is still low while `wake_req` is already high.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int unsigned GPIO_WIDTH_DEF = 8;
    localparam int unsigned GPIO_CHG_LSB_DEF = 4;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PORT = 2'd1,
        RSEL_DIR  = 2'd2
    } rd_sel_e;

    // Port read wins over direction read when both strobes are high.
    function automatic rd_sel_e rd_select(input logic prd, input logic drd);
        if (prd) begin
            return RSEL_PORT;
        end
        if (drd) begin
            return RSEL_DIR;
        end
        return RSEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= '0;
                else     stg[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= '0;
                else     stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
    import gpio_chg_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned PU_BIT = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wdata,
    input  logic         port_wr,
    input  logic         port_rd,
    input  logic         dir_wr,
    input  logic         dir_rd,
    input  logic         pucfg_wr,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dir_lat,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu
);

    logic [W-1:0] dat_q;
    logic [W-1:0] dir_q;
    logic         pu_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q  <= '0;
            dir_q  <= '1;
            pu_n_q <= 1'b1;
        end else begin
            if (port_wr)  dat_q  <= wdata;
            if (dir_wr)   dir_q  <= wdata;
            if (pucfg_wr) pu_n_q <= wdata[PU_BIT];
        end
    end

    rd_sel_e sel;
    assign sel = rd_select(port_rd, dir_rd);

    always_comb begin
        unique case (sel)
            RSEL_PORT: rdata = pin_sync;
            RSEL_DIR:  rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

    assign dir_lat = dir_q;
    assign pin_out = dat_q;
    assign pin_oe  = ~dir_q;
    assign pin_pu  = dir_q & {W{~pu_n_q}};

endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_sync,
    input  logic [N-1:0] is_input,
    input  logic         resync,
    input  logic         clr,
    output logic         mismatch,
    output logic         flag,
    output logic         wake
);

    logic [N-1:0] snap_q;
    logic [N-1:0] diff;
    logic         flag_q;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign diff[i] = (pin_sync[i] ^ snap_q[i]) & is_input[i];
    end

    assign mismatch = |diff;

    always_ff @(posedge clk) begin
        if (rst)         snap_q <= '0;
        else if (resync) snap_q <= pin_sync;
    end

    // A live mismatch takes priority over a clear request.
    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (mismatch) flag_q <= 1'b1;
        else if (clr)      flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign wake = mismatch | flag_q;

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int unsigned WIDTH       = GPIO_WIDTH_DEF,
    parameter int unsigned CHG_LSB     = GPIO_CHG_LSB_DEF,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PU_BIT      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] rd_data,
    input  logic             port_wr,
    input  logic             port_rd,
    input  logic             dir_wr,
    input  logic             dir_rd,
    input  logic             pucfg_wr,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    output logic             chg_flag,
    input  logic             chg_clr,
    output logic             wake_req
);

    localparam int unsigned NCHG = WIDTH - CHG_LSB;

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_lat;
    logic             chg_mismatch;

    gpio_chg_sync #(
        .W      (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_chg_regs #(
        .W      (WIDTH),
        .PU_BIT (PU_BIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wdata    (bus_wdata),
        .port_wr  (port_wr),
        .port_rd  (port_rd),
        .dir_wr   (dir_wr),
        .dir_rd   (dir_rd),
        .pucfg_wr (pucfg_wr),
        .pin_sync (pin_sync),
        .rdata    (rd_data),
        .dir_lat  (dir_lat),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .pin_pu   (pin_pu)
    );

    gpio_chg_detect #(
        .N (NCHG)
    ) u_detect (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync[WIDTH-1:CHG_LSB]),
        .is_input (dir_lat[WIDTH-1:CHG_LSB]),
        .resync   (port_rd | port_wr),
        .clr      (chg_clr),
        .mismatch (chg_mismatch),
        .flag     (chg_flag),
        .wake     (wake_req)
    );

endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] bus_wdata,
    input logic         dir_wr,
    input logic         chg_clr,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_pu,
    input logic         chg_flag,
    input logic         wake_req,
    input logic         chg_mismatch
);

    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (!chg_flag && pin_oe == '0 && pin_pu == '0));

    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
        dir_wr |=> (pin_oe == ~$past(bus_wdata)));

    a_r3_no_pull_on_driven: assert property (@(posedge clk) disable iff (rst)
        ((pin_pu & pin_oe) == '0));

    a_r8_mismatch_sets_flag: assert property (@(posedge clk) disable iff (rst)
        chg_mismatch |=> chg_flag);

    a_r9_clear_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (chg_clr && !chg_mismatch) |=> !chg_flag);

    a_r10_wake_before_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_flag) |-> $past(wake_req));

    a_r10_wake_with_flag: assert property (@(posedge clk) disable iff (rst)
        chg_flag |-> wake_req);

endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wdata    (bus_wdata),
    .dir_wr       (dir_wr),
    .chg_clr      (chg_clr),
    .pin_oe       (pin_oe),
    .pin_pu       (pin_pu),
    .chg_flag     (chg_flag),
    .wake_req     (wake_req),
    .chg_mismatch (chg_mismatch)
);

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rd_data;
    logic       port_wr = 1'b0, port_rd = 1'b0, dir_wr = 1'b0, dir_rd = 1'b0;
    logic       pucfg_wr = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;
    logic       chg_flag, wake_req;
    logic       chg_clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_chg_port u_gpio_chg_port (
        .clk (clk), .rst (rst), .bus_wdata (bus_wdata), .rd_data (rd_data),
        .port_wr (port_wr), .port_rd (port_rd), .dir_wr (dir_wr), .dir_rd (dir_rd),
        .pucfg_wr (pucfg_wr), .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
        .pin_pu (pin_pu), .chg_flag (chg_flag), .chg_clr (chg_clr), .wake_req (wake_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_port(input logic [7:0] v);
        bus_wdata = v; port_wr = 1'b1; tick(); port_wr = 1'b0;
    endtask

    task automatic wr_dir(input logic [7:0] v);
        bus_wdata = v; dir_wr = 1'b1; tick(); dir_wr = 1'b0;
    endtask

    task automatic wr_pucfg(input logic [7:0] v);
        bus_wdata = v; pucfg_wr = 1'b1; tick(); pucfg_wr = 1'b0;
    endtask

    task automatic rd_port(output logic [7:0] v);
        port_rd = 1'b1; #1 v = rd_data; tick(); port_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        chg_clr = 1'b1; tick(); chg_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_pu", pin_pu, 8'h00);
        chk("R1 chg_flag", {7'b0, chg_flag}, 8'h00);
        chk("R1 wake_req", {7'b0, wake_req}, 8'h00);
        chk("R5 idle rd_data", rd_data, 8'h00);
    endtask

    task automatic t_dir_data();
        logic [7:0] v;
        wr_dir(8'hCF);
        chk("R2 oe after 0xCF", pin_oe, 8'h30);
        wr_port(8'hA5);
        chk("R2 pin_out", pin_out, 8'hA5);
        dir_rd = 1'b1; #1 v = rd_data; tick(); dir_rd = 1'b0;
        chk("R5 dir readback", v, 8'hCF);
        pulse_clr();
    endtask

    task automatic t_pullup();
        wr_pucfg(8'h7F);
        chk("R3 pull-ups on inputs only", pin_pu, 8'hCF);
        wr_dir(8'h0F);
        chk("R3 outputs lose pull-up", pin_pu, 8'h0F);
        wr_dir(8'hCF);
        wr_pucfg(8'h80);
        chk("R3 pull-ups off", pin_pu, 8'h00);
    endtask

    task automatic t_read_sync();
        logic [7:0] v;
        pin_in = 8'h5A;
        tick();
        rd_port(v);
        chk("R4 old level after one edge", v, 8'h00);
        rd_port(v);
        chk("R4 new level incl outputs", v, 8'h5A);
        pulse_clr();
        chk("R9 clear after resync", {7'b0, chg_flag}, 8'h00);
    endtask

    task automatic t_lower_ignored();
        pin_in = 8'h55;
        repeat (4) tick();
        chk("R6 lower pins no flag", {7'b0, chg_flag}, 8'h00);
        chk("R6 lower pins no wake", {7'b0, wake_req}, 8'h00);
    endtask

    task automatic t_output_ignored();
        pin_in = 8'h75;
        repeat (4) tick();
        chk("R6 output pin5 no flag", {7'b0, chg_flag}, 8'h00);
        chk("R6 output pin5 no wake", {7'b0, wake_req}, 8'h00);
    endtask

    task automatic t_upper_change();
        logic [7:0] v;
        pin_in = 8'hF5;
        tick(); tick();
        chk("R10 wake before flag", {7'b0, wake_req}, 8'h01);
        chk("R7 flag not yet", {7'b0, chg_flag}, 8'h00);
        tick();
        chk("R7 flag set", {7'b0, chg_flag}, 8'h01);
        pulse_clr();
        chk("R8 clear ignored", {7'b0, chg_flag}, 8'h01);
        rd_port(v);
        chk("R7 flag sticky after resync", {7'b0, chg_flag}, 8'h01);
        chk("R10 wake with flag", {7'b0, wake_req}, 8'h01);
        pulse_clr();
        chk("R9 cleared after read", {7'b0, chg_flag}, 8'h00);
        chk("R10 wake drops", {7'b0, wake_req}, 8'h00);
    endtask

    task automatic t_write_resync();
        pin_in = 8'hB5;
        repeat (3) tick();
        chk("R7 pin6 falling sets flag", {7'b0, chg_flag}, 8'h01);
        wr_port(8'h3C);
        chk("R2 pin_out second write", pin_out, 8'h3C);
        pulse_clr();
        chk("R9 cleared after write", {7'b0, chg_flag}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_dir_data();
        t_pullup();
        t_read_sync();
        t_lower_ignored();
        t_output_ignored();
        t_upper_change();
        t_write_resync();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule